// File: doc/BRIEF.md
# CAN Transmit Buffer Status Controller

This block keeps the status code of one message buffer on the transmit side of a CAN controller. Software arms the buffer by writing a 4-bit command code into the status field. The block then raises a transmit request towards the scheduler. When the scheduler grants the request, the status moves to the busy form of the command. When the frame goes out, or when the attempt fails, the status moves to the code that follows.

Besides one-shot transmission, the buffer has an automatic remote-reply mode. In this mode the buffer sends its data once and then parks in a remote-wait state. Each time a matching remote frame comes in, it re-arms itself and sends its data again. A buffer that successfully sends a remote frame turns into a receive-ready buffer, so it can take in the answer.

Top module: `can_txbuf_status`

## Requirements
- R1: While reset is asserted and after it is released, the status is 4'b1000 (inactive) and `tx_req` is low.
- R2: While the status is not busy (bit 0 clear), a write of a code whose bit 0 is clear is stored as written in the next cycle. The codes are: inactive 4'b1000, one-shot 4'b1100, remote-wait 4'b1010, one-shot-then-remote-wait 4'b1110, receive-ready 4'b0010.
- R3: A write of any code with bit 0 set is ignored, and the status stays unchanged.
- R4: `tx_req` is high exactly when the status is 4'b1100 or 4'b1110.
- R5: A grant while `tx_req` is high sets bit 0 of the status in the next cycle, so 4'b1100 becomes 4'b1101 and 4'b1110 becomes 4'b1111. A grant while `tx_req` is low has no effect.
- R6: In status 4'b1101, `tx_ok` with `tx_remote` low (a data frame) gives status 4'b1000.
- R7: In status 4'b1101, `tx_ok` with `tx_remote` high (a remote frame) gives status 4'b0010.
- R8: In status 4'b1111, `tx_ok` gives status 4'b1010, whatever the frame type.
- R9: In status 4'b1010, `rtr_match` gives status 4'b1110. In every other state `rtr_match` has no effect.
- R10: While busy, `tx_fail` without `tx_ok` clears bit 0, which restores the command held before the grant. `tx_ok` wins over `tx_fail`. Both pulses have no effect when the status is not busy.
- R11: While busy, CPU writes are ignored.
- R12: While not busy, an accepted write wins over a grant and over `rtr_match` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe for the status field |
| wr_status | input | 4 | Status code written by the CPU |
| sched_grant | input | 1 | Scheduler has picked this buffer for transmission |
| tx_ok | input | 1 | Frame from this buffer sent successfully (pulse) |
| tx_remote | input | 1 | Qualifies `tx_ok`: 1 means a remote frame was sent, 0 a data frame |
| tx_fail | input | 1 | Transmission attempt failed or lost arbitration (pulse) |
| rtr_match | input | 1 | Matching remote frame received for this buffer (pulse) |
| status | output | 4 | Current buffer status code |
| tx_req | output | 1 | Buffer is armed and waiting for the scheduler |

## Verification
On every cycle, the assertions check these properties:
- `tx_req` is never high in a busy state.
- Writes during busy leave the status untouched.
- Each completion or failure pulse lands on its successor code.
- A grant or a remote match moves the status one step.

Only the bench's scenarios can show the following, because they depend on several inputs colliding in one cycle and on sequences of events:
- The full auto-reply loop from remote-wait through a failed retry and back.
- The precedence of a write over a grant or a remote match in the same cycle.
- The rejection of odd codes.

// File: rtl/can_txbuf_pkg.sv
package can_txbuf_pkg;

    localparam int unsigned CODE_W   = 4;
    localparam int unsigned BUSY_BIT = 0;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_IDLE      = 4'b1000;
    localparam code_t CODE_ONCE      = 4'b1100;
    localparam code_t CODE_WAIT_RMT  = 4'b1010;
    localparam code_t CODE_ONCE_WAIT = 4'b1110;
    localparam code_t CODE_RX_RDY    = 4'b0010;

    localparam code_t BUSY_MASK = code_t'(1) << BUSY_BIT;

    typedef struct packed {
        code_t status;
    } buf_state_t;

    function automatic code_t busy_form(input code_t c);
        return c | BUSY_MASK;
    endfunction

    function automatic code_t cmd_form(input code_t c);
        return c & ~BUSY_MASK;
    endfunction

endpackage

// File: rtl/txbuf_req_decode.sv
module txbuf_req_decode
    import can_txbuf_pkg::*;
(
    input  code_t status,
    output logic  busy,
    output logic  req
);
    always_comb begin
        busy = status[BUSY_BIT];
        req  = (status == CODE_ONCE) || (status == CODE_ONCE_WAIT);
    end
endmodule

// File: rtl/txbuf_cmd_filter.sv
module txbuf_cmd_filter
    import can_txbuf_pkg::*;
(
    input  logic  wr_en,
    input  code_t wr_status,
    input  logic  busy,
    output logic  wr_accept
);
    // A write is taken only in a stable state and only for a command form.
    always_comb begin
        wr_accept = wr_en && !busy && !wr_status[BUSY_BIT];
    end
endmodule

// File: rtl/txbuf_next_state.sv
module txbuf_next_state
    import can_txbuf_pkg::*;
(
    input  code_t cur,
    input  logic  busy,
    input  logic  req,
    input  logic  wr_accept,
    input  code_t wr_status,
    input  logic  grant,
    input  logic  tx_ok,
    input  logic  tx_remote,
    input  logic  tx_fail,
    input  logic  rtr_match,
    output code_t nxt
);
    always_comb begin
        nxt = cur;
        if (busy) begin
            if (tx_ok) begin
                if (cur == busy_form(CODE_ONCE_WAIT)) begin
                    nxt = CODE_WAIT_RMT;
                end else if (tx_remote) begin
                    nxt = CODE_RX_RDY;
                end else begin
                    nxt = CODE_IDLE;
                end
            end else if (tx_fail) begin
                nxt = cmd_form(cur);
            end
        end else if (wr_accept) begin
            nxt = wr_status;
        end else if (req && grant) begin
            nxt = busy_form(cur);
        end else if (rtr_match && (cur == CODE_WAIT_RMT)) begin
            nxt = CODE_ONCE_WAIT;
        end
    end
endmodule

// File: rtl/can_txbuf_status.sv
module can_txbuf_status
    import can_txbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_status,
    input  logic              sched_grant,
    input  logic              tx_ok,
    input  logic              tx_remote,
    input  logic              tx_fail,
    input  logic              rtr_match,
    output logic [CODE_W-1:0] status,
    output logic              tx_req
);
    buf_state_t state_d, state_q;
    logic       busy;
    logic       req;
    logic       wr_accept;
    code_t      nxt_status;

    txbuf_req_decode u_decode (
        .status (state_q.status),
        .busy   (busy),
        .req    (req)
    );

    txbuf_cmd_filter u_filter (
        .wr_en     (wr_en),
        .wr_status (wr_status),
        .busy      (busy),
        .wr_accept (wr_accept)
    );

    txbuf_next_state u_next (
        .cur       (state_q.status),
        .busy      (busy),
        .req       (req),
        .wr_accept (wr_accept),
        .wr_status (wr_status),
        .grant     (sched_grant),
        .tx_ok     (tx_ok),
        .tx_remote (tx_remote),
        .tx_fail   (tx_fail),
        .rtr_match (rtr_match),
        .nxt       (nxt_status)
    );

    always_comb begin
        state_d        = state_q;
        state_d.status = nxt_status;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.status <= CODE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign status = state_q.status;
    assign tx_req = req;
endmodule

// File: rtl/can_txbuf_status_chk.sv
module can_txbuf_status_chk
    import can_txbuf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              sched_grant,
    input logic              tx_ok,
    input logic              tx_remote,
    input logic              tx_fail,
    input logic              rtr_match,
    input logic [CODE_W-1:0] status,
    input logic              tx_req
);
    // R4
    req_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> !status[BUSY_BIT]);

    // R11
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BUSY_BIT] && wr_en && !tx_ok && !tx_fail) |=> $stable(status));

    // R5
    grant_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && sched_grant && !wr_en) |=> (status == ($past(status) | BUSY_MASK)));

    // R6
    data_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 4'b1101 && tx_ok && !tx_remote) |=> (status == CODE_IDLE));

    // R7
    remote_done_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 4'b1101 && tx_ok && tx_remote) |=> (status == CODE_RX_RDY));

    // R8
    reply_done_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 4'b1111 && tx_ok) |=> (status == CODE_WAIT_RMT));

    // R9
    remote_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == CODE_WAIT_RMT && rtr_match && !wr_en) |=> (status == CODE_ONCE_WAIT));

    // R10
    fail_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BUSY_BIT] && tx_fail && !tx_ok) |=>
            (status == {$past(status[CODE_W-1:1]), 1'b0}));
endmodule

bind can_txbuf_status can_txbuf_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .sched_grant (sched_grant),
    .tx_ok       (tx_ok),
    .tx_remote   (tx_remote),
    .tx_fail     (tx_fail),
    .rtr_match   (rtr_match),
    .status      (status),
    .tx_req      (tx_req)
);

// File: tb/tb_can_txbuf_status.sv
`timescale 1ns/1ps
module tb_can_txbuf_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_status = 4'b0;
    logic       sched_grant = 1'b0;
    logic       tx_ok = 1'b0;
    logic       tx_remote = 1'b0;
    logic       tx_fail = 1'b0;
    logic       rtr_match = 1'b0;
    logic [3:0] status;
    logic       tx_req;

    int checks = 0;
    int errors = 0;
    int exp_code = 8;       // expected status as integer
    string tag = "R1";

    always #2 clk = ~clk;   // 250 MHz

    can_txbuf_status dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_status(wr_status),
        .sched_grant(sched_grant), .tx_ok(tx_ok), .tx_remote(tx_remote),
        .tx_fail(tx_fail), .rtr_match(rtr_match),
        .status(status), .tx_req(tx_req)
    );

    task automatic compare();
        bit exp_req;
        exp_req = (exp_code == 12) || (exp_code == 14);
        checks++;
        if (status !== 4'(exp_code)) begin
            errors++;
            $display("FAIL %s status actual %b expected %b", tag, status, 4'(exp_code));
        end
        checks++;
        if (tx_req !== exp_req) begin
            errors++;
            $display("FAIL R4 tx_req actual %b expected %b (status %b)", tx_req, exp_req, 4'(exp_code));
        end
    endtask

    // Reference: decide the code after this cycle from the requirement list.
    task automatic model();
        bit busy_now;
        bit req_now;
        busy_now = (exp_code % 2) == 1;
        req_now  = (exp_code == 12) || (exp_code == 14);
        if (busy_now) begin
            if (tx_ok) begin
                if (exp_code == 15) begin exp_code = 10; tag = "R8"; end
                else if (tx_remote) begin exp_code = 2; tag = "R7"; end
                else begin exp_code = 8; tag = "R6"; end
            end else if (tx_fail) begin
                exp_code = exp_code - 1; tag = "R10";
            end else begin
                tag = wr_en ? "R11" : "R5";
            end
        end else if (wr_en && (wr_status % 2 == 0)) begin
            exp_code = int'(wr_status);
            tag = (sched_grant || rtr_match) ? "R12" : "R2";
        end else if (req_now && sched_grant) begin
            exp_code = exp_code + 1; tag = "R5";
        end else if (rtr_match && exp_code == 10) begin
            exp_code = 14; tag = "R9";
        end else begin
            if (wr_en) tag = "R3";
            else if (tx_ok || tx_fail) tag = "R10";
            else if (rtr_match) tag = "R9";
            else tag = "R5";
        end
    endtask

    task automatic cyc(input bit we, input logic [3:0] ws, input bit g,
                       input bit ok, input bit rm, input bit fl, input bit rtr);
        wr_en = we; wr_status = ws; sched_grant = g;
        tx_ok = ok; tx_remote = rm; tx_fail = fl; rtr_match = rtr;
        model();
        @(negedge clk);
        compare();
    endtask

    task automatic idle_cyc();
        cyc(0, 4'b0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        tag = "R1";
        compare();
        rst_n = 1'b1;
        @(negedge clk);
        compare();

        // one-shot data frame: R2, R5, R6
        cyc(1, 4'b1100, 0, 0, 0, 0, 0);
        idle_cyc();
        cyc(0, 4'b0, 1, 0, 0, 0, 0);
        cyc(0, 4'b0, 0, 1, 0, 0, 0);

        // one-shot remote frame: R7
        cyc(1, 4'b1100, 0, 0, 0, 0, 0);
        cyc(0, 4'b0, 1, 0, 0, 0, 0);
        cyc(0, 4'b0, 0, 1, 1, 0, 0);

        // auto-reply loop: R8, R9, R10, R11
        cyc(0, 4'b0, 0, 0, 0, 0, 1);          // R9 ignored in 0010
        cyc(1, 4'b1110, 0, 0, 0, 0, 0);
        cyc(0, 4'b0, 1, 0, 0, 0, 0);          // 1111
        cyc(1, 4'b1000, 0, 0, 0, 0, 0);       // R11 ignored
        cyc(0, 4'b0, 0, 1, 1, 0, 0);          // R8 -> 1010
        cyc(0, 4'b0, 1, 0, 0, 0, 0);          // R5 grant without request
        cyc(0, 4'b0, 0, 0, 0, 0, 1);          // R9 -> 1110
        cyc(0, 4'b0, 1, 0, 0, 0, 0);          // 1111
        cyc(0, 4'b0, 0, 0, 0, 1, 0);          // R10 -> 1110
        cyc(0, 4'b0, 1, 0, 0, 0, 0);
        cyc(0, 4'b0, 0, 1, 0, 1, 0);          // R10 ok wins -> 1010

        // direct remote-wait write: R2, R9
        cyc(1, 4'b1000, 0, 0, 0, 0, 0);
        cyc(1, 4'b1010, 0, 0, 0, 0, 0);
        idle_cyc();
        cyc(0, 4'b0, 0, 0, 0, 0, 1);

        // odd codes ignored: R3
        cyc(1, 4'b1101, 0, 0, 0, 0, 0);
        cyc(1, 4'b0011, 0, 0, 0, 0, 0);
        cyc(1, 4'b1111, 0, 0, 0, 0, 0);

        // write wins over grant / rtr_match: R12
        cyc(1, 4'b1100, 1, 0, 0, 0, 0);
        cyc(1, 4'b1010, 0, 0, 0, 0, 0);
        cyc(1, 4'b0010, 0, 0, 0, 0, 1);
        // pulses with nothing in flight: R10
        cyc(0, 4'b0, 0, 1, 0, 0, 0);
        cyc(0, 4'b0, 0, 0, 0, 1, 0);

        // random traffic against the reference
        for (int i = 0; i < 2000; i++) begin
            logic [3:0] pick;
            pick = 4'($urandom_range(0, 7));
            cyc(($urandom_range(0, 5) == 0),
                (pick == 0) ? 4'b1100 : (pick == 1) ? 4'b1110 : (pick == 2) ? 4'b1010 :
                (pick == 3) ? 4'b1000 : (pick == 4) ? 4'b0010 : 4'($urandom_range(0, 15)),
                ($urandom_range(0, 2) == 0), ($urandom_range(0, 3) == 0),
                1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
                ($urandom_range(0, 3) == 0));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule